// File: doc/BRIEF.md
# Byte-wide ROM longword read sequencer

This block sits between a 32-bit local bus and an 8-bit EPROM or flash device. A one-clock request pulse with a longword address starts a read. The block then runs four back-to-back byte accesses to the device, stepping the two low address bits through 0, 1, 2 and 3. Each access is held for a window of bus clocks that software sets through a 3-bit wait code.

Each byte is sampled on the last clock of its window and shifted into a longword, first byte in the top lane. After the fourth byte is in, the block raises a one-clock acknowledge and presents the assembled 32-bit word. The device output enable stays low, without a break, across the four windows.

The controller has three states. `ST_IDLE` waits for a request. The transition *start* (request seen) loads the address and the window length and enters `ST_FETCH`. In `ST_FETCH`, the transition *next byte* (window over, fewer than four bytes done) keeps the state and steps the byte index. The transition *last byte* (fourth window over) enters `ST_ACK`. The transition *release* always returns from `ST_ACK` to `ST_IDLE` one clock later.

Top module: `rom_lword_seq`

## Requirements
- R1: After reset, `bus_ack` is 0, `rom_oe_n` is 1 and `bus_rdata` is 0.
- R2: A request pulse seen in `ST_IDLE` starts a transfer. `rom_addr` carries the upper request address bits, with byte offsets 0, 1, 2, 3 in that order in its two low bits.
- R3: Each byte window lasts 3 + `wait_code` clocks. Codes 0 to 7 give 3 to 10 clocks, so one longword takes 12 to 40 clocks.
- R4: Each byte is sampled from `rom_data` on the last clock of its window only.
- R5: The byte at offset 0 is placed in `bus_rdata[31:24]` and the byte at offset 3 in `bus_rdata[7:0]`.
- R6: `bus_ack` is high for exactly one clock. That clock is the 4·(3+`wait_code`)+1-th clock after the edge that accepted the request.
- R7: `rom_oe_n` is low for exactly the 4·(3+`wait_code`) window clocks. It is high in the acknowledge clock and while idle.
- R8: `wait_code` is taken when a request is accepted. Changing it during a transfer does not alter that transfer's timing.
- R9: A request pulse while a transfer is running is ignored. It changes neither the running transfer's address nor its data, and it adds no acknowledge.
- R10: `bus_rdata` changes only in the acknowledge clock and holds its value until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | One-clock read request pulse |
| bus_addr | input | ADDR_W | Longword address; the two low bits are ignored |
| wait_code | input | WAIT_W | Byte window length code (3 + code clocks) |
| bus_ack | output | 1 | One-clock transfer acknowledge |
| bus_rdata | output | 32 | Assembled longword |
| rom_addr | output | ADDR_W | Byte address to the device |
| rom_oe_n | output | 1 | Active-low device output enable |
| rom_data | input | 8 | Byte data from the device |

## Verification
Embedded assertions check several properties on every clock. Acknowledge and output enable are never active together. Acknowledge never lasts two clocks. The window counter stays inside the latched length. The byte index only steps upward by one. The latched length and base address stay put while a transfer runs. The read data changes only into an acknowledge clock.

Some behaviour can only be shown by the bench's scenarios. These are the exact 4L+1 latency, the output-enable clock count, and big-endian placement. Sampling on the last clock of each window shows up because the device model drives valid data only then. The bench also shows that a mid-transfer wait-code change or a second request leaves the transfer untouched.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ACK   = 2'd2
    } seq_state_t;

    localparam int unsigned LANES = 4;
    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/rom_win_timer.sv
module rom_win_timer #(
    parameter int unsigned WAIT_W    = 3,
    parameter int unsigned BASE_CLKS = 3,
    localparam int unsigned MAX_LEN  = BASE_CLKS + (1 << WAIT_W) - 1,
    localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_code,
    output logic              win_last
);
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CNT_W'(BASE_CLKS);
            cnt_q <= '0;
        end else if (start) begin
            len_q <= CNT_W'(BASE_CLKS) + CNT_W'(wait_code);
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= win_last ? '0 : cnt_q + 1'b1;
        end
    end

    assign win_last = (cnt_q == len_q - 1'b1);

    // R3: the counter never runs past the latched window length
    p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_q);
    // R8: window length stays fixed while the window is counting
    p_len_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> $stable(len_q));
endmodule

// File: rtl/rom_lane_pack.sv
module rom_lane_pack
    import rom_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic                      final_byte,
    input  logic [LANE_W-1:0]         byte_in,
    output logic [LANES*LANE_W-1:0]   word_out
);
    logic [(LANES-1)*LANE_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            word_out <= '0;
        end else if (capture) begin
            shift_q <= {shift_q[(LANES-2)*LANE_W-1:0], byte_in};
            if (final_byte)
                word_out <= {shift_q, byte_in};
        end
    end
endmodule

// File: rtl/rom_lword_seq.sv
module rom_lword_seq
    import rom_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned WAIT_W    = 3,
    parameter int unsigned BASE_CLKS = 3,
    localparam int unsigned IDX_W    = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WAIT_W-1:0]       wait_code,
    output logic                    bus_ack,
    output logic [LANES*LANE_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0]       rom_addr,
    output logic                    rom_oe_n,
    input  logic [LANE_W-1:0]       rom_data
);
    seq_state_t state_q, state_d;
    logic [ADDR_W-IDX_W-1:0] base_q;
    logic [IDX_W-1:0]        idx_q;
    logic                    win_last;
    logic                    start;
    logic                    in_fetch;
    logic                    capture;
    logic                    final_byte;

    assign start      = (state_q == ST_IDLE) && bus_req;
    assign in_fetch   = (state_q == ST_FETCH);
    assign capture    = in_fetch && win_last;
    assign final_byte = (idx_q == IDX_W'(LANES - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_req) state_d = ST_FETCH;
            ST_FETCH: if (capture && final_byte) state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register with address and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                base_q <= bus_addr[ADDR_W-1:IDX_W];
                idx_q  <= '0;
            end else if (capture && !final_byte) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        bus_ack  = 1'b0;
        rom_oe_n = 1'b1;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: rom_oe_n = 1'b0;
            ST_ACK:   bus_ack  = 1'b1;
            default:  ;
        endcase
    end

    assign rom_addr = {base_q, idx_q};

    rom_win_timer #(
        .WAIT_W    (WAIT_W),
        .BASE_CLKS (BASE_CLKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (in_fetch),
        .wait_code (wait_code),
        .win_last  (win_last)
    );

    rom_lane_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .final_byte (final_byte),
        .byte_in    (rom_data),
        .word_out   (bus_rdata)
    );

    // R7: enable and acknowledge are never active in the same clock
    p_oe_ack_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && !rom_oe_n));
    // R6: acknowledge lasts one clock
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    // R2: within a transfer the byte offset only steps up by one
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && !$stable(idx_q)) |-> (idx_q == $past(idx_q) + 1'b1));
    // R9: base address is frozen outside the idle state
    p_base_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(base_q));
    // R10: read data moves only into an acknowledge clock
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> $stable(bus_rdata));
endmodule

// File: tb/rom_lword_seq_test.sv
module rom_lword_seq_test;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [2:0]        wait_code = '0;
    logic              bus_ack;
    logic [31:0]       bus_rdata;
    logic [ADDR_W-1:0] rom_addr;
    logic              rom_oe_n;
    logic [7:0]        rom_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acks = 0;
    int oe_cnt = 0;
    int dev_len = 3;
    logic prev_ack = 1'b0;
    logic [31:0] last_word = '0;

    logic [31:0] q_data[$];
    int          q_lat[$];
    int          q_t0[$];
    int          q_len[$];

    always #5 clk = ~clk;

    rom_lword_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .wait_code (wait_code),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .rom_addr  (rom_addr),
        .rom_oe_n  (rom_oe_n),
        .rom_data  (rom_data)
    );

    function automatic logic [7:0] dbyte(input logic [ADDR_W-1:0] a);
        return (a[7:0] * 8'd29 + a[15:8] + {4'h0, a[19:16]}) & 8'h7F;
    endfunction

    // device model: valid data only once the address has been stable for len-1 edges
    logic [ADDR_W-1:0] last_addr = '0;
    int                stable_cnt = 0;
    always @(posedge clk) begin
        stable_cnt <= (rom_addr == last_addr) ? stable_cnt + 1 : 1;
        last_addr  <= rom_addr;
        cyc        <= cyc + 1;
    end
    assign rom_data = (rom_addr == last_addr && stable_cnt >= dev_len - 1)
                      ? dbyte(rom_addr) : 8'hEE;

    task automatic chk(input bit ok, input string r, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // driver: starts a read and pushes the expected result
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [2:0] w,
                           input bit mid_change, input bit extra_req);
        int target;
        logic [31:0] exp;
        target = acks + 1;
        exp = {dbyte({a[ADDR_W-1:2], 2'd0}), dbyte({a[ADDR_W-1:2], 2'd1}),
               dbyte({a[ADDR_W-1:2], 2'd2}), dbyte({a[ADDR_W-1:2], 2'd3})};
        @(negedge clk);
        bus_addr  = a;
        wait_code = w;
        bus_req   = 1'b1;
        dev_len   = 3 + int'(w);
        q_data.push_back(exp);
        q_lat.push_back(4 * (3 + int'(w)) + 1);
        q_t0.push_back(cyc);
        q_len.push_back(4 * (3 + int'(w)));
        @(negedge clk);
        bus_req = 1'b0;
        if (mid_change) begin
            repeat (2) @(negedge clk);
            wait_code = ~w;          // R8: must not alter this transfer
        end
        if (extra_req) begin
            repeat (3) @(negedge clk);
            bus_addr = a ^ 20'h0FF00; // R9: ignored request
            bus_req  = 1'b1;
            @(negedge clk);
            bus_req  = 1'b0;
        end
        while (acks < target) @(negedge clk);
    endtask

    // monitor: pops expected items as acknowledges appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rom_oe_n) oe_cnt++;
            if (bus_ack) begin
                chk(!prev_ack, "R6 single-clock ack", 32'(prev_ack), 0);
                if (q_data.size() == 0) begin
                    chk(0, "R9 unexpected ack", 1, 0);
                end else begin
                    int lat, t0, ol;
                    logic [31:0] e;
                    e = q_data.pop_front();
                    lat = q_lat.pop_front();
                    t0 = q_t0.pop_front();
                    ol = q_len.pop_front();
                    chk(bus_rdata == e, "R4/R5 longword", bus_rdata, e);
                    chk(cyc - t0 == lat, "R3/R6 latency", 32'(cyc - t0), 32'(lat));
                    chk(oe_cnt == ol, "R7 oe clocks", 32'(oe_cnt), 32'(ol));
                    chk(rom_oe_n == 1'b1, "R7 oe high in ack", 32'(rom_oe_n), 1);
                    last_word = e;
                end
                oe_cnt = 0;
                acks++;
            end
            prev_ack = bus_ack;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_ack == 1'b0, "R1 ack", 32'(bus_ack), 0);
        chk(rom_oe_n == 1'b1, "R1 oe_n", 32'(rom_oe_n), 1);
        chk(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R5: shortest and longest windows
        do_read(20'h01230, 3'd0, 0, 0);
        do_read(20'hABCD4, 3'd7, 0, 0);
        do_read(20'h5555B, 3'd3, 0, 0);   // low bits ignored (R2)
        // R8: wait code changed mid-transfer
        do_read(20'h00F08, 3'd1, 1, 0);
        // R9: request while busy
        do_read(20'h7A31C, 3'd5, 0, 1);
        // R10: data held while idle
        repeat (5) @(negedge clk);
        chk(bus_rdata == last_word, "R10 hold", bus_rdata, last_word);
        chk(rom_oe_n == 1'b1, "R7 idle oe_n", 32'(rom_oe_n), 1);
        // back-to-back requests
        do_read(20'hFFFFC, 3'd2, 0, 0);
        do_read(20'h00000, 3'd6, 0, 0);
        repeat (4) @(negedge clk);
        chk(q_data.size() == 0, "R9 pending items", 32'(q_data.size()), 0);
        chk(bus_ack == 1'b0, "R6 ack low after", 32'(bus_ack), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule